// File: doc/BRIEF.md
# Single-Cycle 32-bit Subset Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction every clock cycle. It executes a nine-instruction subset: four register-register logic and arithmetic operations, a signed set-on-less-than, a word load, a word store, a conditional branch on equality and an absolute jump within the current 256 MB region. All state (program counter, register file, data memory) changes only on the rising clock edge. Everything else between two edges is combinational: decode, operand read, ALU, memory read, result selection and next-PC selection.

Instruction and data storage are word-addressed arrays inside the core. A testbench preloads them before reset is released. The core exposes a retirement trace on its ports. The trace gives the current PC, the fetched instruction word, the register write strobe with its target and value, and the data memory write strobe with its address and value. This trace is how the core is observed.

Top module: `scpu_core`

## Requirements
- R1: A synchronous active-high reset loads the program counter with 0 on the rising edge where reset is high.
- R2: Each cycle fetches the word at PC[31:2]. An instruction that is not a taken branch or a jump sets the next PC to PC+4.
- R3: Opcode 0x00 with funct 0x20/0x22/0x24/0x25 writes R[rs]+R[rt], R[rs]-R[rt], R[rs]&R[rt] or R[rs]|R[rt] into register rd. Fields: rs = [25:21], rt = [20:16], rd = [15:11], funct = [5:0].
- R4: Opcode 0x00 with funct 0x2A writes 1 into rd when R[rs] < R[rt] as signed values, and 0 otherwise.
- R5: Opcode 0x23 (load) reads the data word at R[rs] + sign-extended imm[15:0] and writes it into rt.
- R6: Opcode 0x2B (store) writes R[rt] to the data word at R[rs] + sign-extended imm[15:0] and does not write a register.
- R7: Opcode 0x04 (branch-equal) sets the next PC to (PC+4) + (sign-extended imm << 2) when R[rs] equals R[rt], and to PC+4 otherwise. It writes nothing.
- R8: Opcode 0x02 (jump) sets the next PC to {(PC+4)[31:28], instr[25:0], 2'b00} and writes nothing.
- R9: Register 0 always reads as zero. A write aimed at it leaves it at zero.
- R10: Any other opcode writes neither a register nor memory and advances the PC by 4.
- R11: An instruction whose destination is also one of its sources uses the value the register held before that instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pcOut | output | 32 | Address of the instruction executing this cycle |
| instrOut | output | 32 | Instruction word fetched this cycle |
| regWrEn | output | 1 | Register write strobe for this instruction |
| regWrAddr | output | 5 | Destination register number |
| regWrData | output | 32 | Value to be written into the destination |
| memWrEn | output | 1 | Data memory write strobe |
| memAddr | output | 32 | Data memory byte address (ALU result) |
| memWrData | output | 32 | Data to be stored |

## Verification
Two things meet in one cycle in this core. A source register is read, and the same register is written on the closing edge. One instruction doubles a register into itself, and a store afterwards exposes the outcome. The expected value is built from the pre-edge contents. A store followed by a load of the same word checks that memory written on one edge is visible to the next instruction. Taken and not-taken branches, a jump, a write to register 0 and an undefined opcode are each judged through the PC and write strobes of the following cycle.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

  localparam int XLEN    = 32;
  localparam int REG_AW  = 5;
  localparam int NREGS   = 1 << REG_AW;
  localparam int OP_W    = 6;
  localparam int FUNCT_W = 6;
  localparam int IMM_W   = 16;
  localparam int JIDX_W  = 26;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;

  localparam logic [FUNCT_W-1:0] FN_ADD = 6'h20;
  localparam logic [FUNCT_W-1:0] FN_SUB = 6'h22;
  localparam logic [FUNCT_W-1:0] FN_AND = 6'h24;
  localparam logic [FUNCT_W-1:0] FN_OR  = 6'h25;
  localparam logic [FUNCT_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } aluOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic   regWrite;
    logic   dstIsRd;
    logic   aluSrcImm;
    logic   memRead;
    logic   memWrite;
    logic   memToReg;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
  } ctrl_t;

endpackage

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic [OP_W-1:0]    opcode,
  input  logic [FUNCT_W-1:0] funct,
  output ctrl_t              ctrl
);

  aluOp_e rAluOp;
  logic   rKnown;

  // Secondary decode of the funct field for register-register ops
  always_comb begin
    rKnown = 1'b1;
    unique case (funct)
      FN_ADD:  rAluOp = ALU_ADD;
      FN_SUB:  rAluOp = ALU_SUB;
      FN_AND:  rAluOp = ALU_AND;
      FN_OR:   rAluOp = ALU_OR;
      FN_SLT:  rAluOp = ALU_SLT;
      default: begin
        rAluOp = ALU_ADD;
        rKnown = 1'b0;
      end
    endcase
  end

  // Primary decode on the opcode; anything unlisted stays quiet
  always_comb begin
    ctrl       = '0;
    ctrl.aluOp = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.regWrite = rKnown;
        ctrl.dstIsRd  = 1'b1;
        ctrl.aluOp    = rAluOp;
      end
      OP_LOAD: begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memRead   = 1'b1;
        ctrl.memToReg  = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      OP_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
  import scpu_pkg::*;
#(
  parameter int WIDTH = XLEN,
  parameter int AW    = REG_AW
) (
  input  logic             clk,
  input  logic [AW-1:0]    rdAddrA,
  input  logic [AW-1:0]    rdAddrB,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData
);

  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] regs [DEPTH];

  // Entry 0 is never stored; it is a constant zero on both read ports
  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) regs[wrAddr] <= wrData;
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/scpu_wordmem.sv
module scpu_wordmem #(
  parameter int WIDTH = 32,
  parameter int WORDS = 64,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic [AW-1:0]    wordIdx,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData
);

  logic [WIDTH-1:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (wrEn) words[wordIdx] <= wrData;
  end

  assign rdData = rdEn ? words[wordIdx] : '0;

endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  output logic [OP_W-1:0]    opcode,
  output logic [FUNCT_W-1:0] funct,
  output logic [XLEN-1:0]    pcOut,
  output logic [XLEN-1:0]    instrOut,
  output logic [REG_AW-1:0]  regWrAddr,
  output logic [XLEN-1:0]    regWrData,
  output logic [XLEN-1:0]    memAddr,
  output logic [XLEN-1:0]    memWrData
);

  localparam int IAW    = $clog2(IMEM_WORDS);
  localparam int DAW    = $clog2(DMEM_WORDS);
  localparam int SHIFT2 = 2;

  logic [XLEN-1:0]   pc, pcNext, pcPlus4, brTarget, jTarget;
  logic [XLEN-1:0]   instr;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx;
  logic [IMM_W-1:0]  imm;
  logic [XLEN-1:0]   immExt;
  logic [XLEN-1:0]   srcA, srcB, aluB, aluRes, memRdata, wbData;
  logic              aluZero;

  // Program counter
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  scpu_wordmem #(.WIDTH(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk    (clk),
    .wordIdx(pc[IAW+SHIFT2-1:SHIFT2]),
    .rdEn   (1'b1),
    .rdData (instr),
    .wrEn   (1'b0),
    .wrData ('0)
  );

  assign opcode = instr[31:26];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign funct  = instr[FUNCT_W-1:0];
  assign imm    = instr[IMM_W-1:0];
  assign immExt = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

  assign regWrAddr = ctrl.dstIsRd ? rdIdx : rtIdx;

  scpu_regfile u_rf (
    .clk    (clk),
    .rdAddrA(rsIdx),
    .rdAddrB(rtIdx),
    .rdDataA(srcA),
    .rdDataB(srcB),
    .wrEn   (ctrl.regWrite),
    .wrAddr (regWrAddr),
    .wrData (wbData)
  );

  // ALU
  assign aluB = ctrl.aluSrcImm ? immExt : srcB;

  always_comb begin
    unique case (ctrl.aluOp)
      ALU_AND: aluRes = srcA & aluB;
      ALU_OR:  aluRes = srcA | aluB;
      ALU_ADD: aluRes = srcA + aluB;
      ALU_SUB: aluRes = srcA - aluB;
      ALU_SLT: aluRes = {{(XLEN-1){1'b0}}, ($signed(srcA) < $signed(aluB))};
      default: aluRes = '0;
    endcase
  end

  assign aluZero = (aluRes == '0);

  scpu_wordmem #(.WIDTH(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk    (clk),
    .wordIdx(aluRes[DAW+SHIFT2-1:SHIFT2]),
    .rdEn   (ctrl.memRead),
    .rdData (memRdata),
    .wrEn   (ctrl.memWrite),
    .wrData (srcB)
  );

  assign wbData = ctrl.memToReg ? memRdata : aluRes;

  // Next-PC selection
  assign pcPlus4  = pc + XLEN'(4);
  assign brTarget = pcPlus4 + {immExt[XLEN-SHIFT2-1:0], {SHIFT2{1'b0}}};
  assign jTarget  = {pcPlus4[XLEN-1:JIDX_W+SHIFT2], instr[JIDX_W-1:0], {SHIFT2{1'b0}}};

  always_comb begin
    if (ctrl.jump)                   pcNext = jTarget;
    else if (ctrl.branch && aluZero) pcNext = brTarget;
    else                             pcNext = pcPlus4;
  end

  assign pcOut     = pc;
  assign instrOut  = instr;
  assign regWrData = wbData;
  assign memAddr   = aluRes;
  assign memWrData = srcB;

endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   instrOut,
  output logic              regWrEn,
  output logic [REG_AW-1:0] regWrAddr,
  output logic [XLEN-1:0]   regWrData,
  output logic              memWrEn,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWrData
);

  ctrl_t              ctrl;
  logic [OP_W-1:0]    opcode;
  logic [FUNCT_W-1:0] funct;

  scpu_control u_control (
    .opcode(opcode),
    .funct (funct),
    .ctrl  (ctrl)
  );

  scpu_datapath #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .opcode   (opcode),
    .funct    (funct),
    .pcOut    (pcOut),
    .instrOut (instrOut),
    .regWrAddr(regWrAddr),
    .regWrData(regWrData),
    .memAddr  (memAddr),
    .memWrData(memWrData)
  );

  assign regWrEn = ctrl.regWrite;
  assign memWrEn = ctrl.memWrite;

endmodule

// File: rtl/scpu_core_checker.sv
module scpu_core_checker
  import scpu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   pcOut,
  input logic [XLEN-1:0]   instrOut,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regWrAddr,
  input logic              memWrEn
);

  logic [OP_W-1:0] op;
  logic [XLEN-1:0] seqPc, brTgt, jTgt;
  logic            isKnown;

  assign op      = instrOut[31:26];
  assign seqPc   = pcOut + 32'd4;
  assign brTgt   = seqPc + {{14{instrOut[15]}}, instrOut[15:0], 2'b00};
  assign jTgt    = {seqPc[31:28], instrOut[25:0], 2'b00};
  assign isKnown = (op == OP_RTYPE) || (op == OP_LOAD) || (op == OP_STORE) ||
                   (op == OP_BEQ) || (op == OP_JUMP);

  // R1
  a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pcOut == '0));

  // R2
  a_r2_seq_pc: assert property (@(posedge clk) disable iff (rst)
    ((op != OP_BEQ) && (op != OP_JUMP)) |=> (pcOut == $past(seqPc)));

  // R5
  a_r5_load_dest: assert property (@(posedge clk) disable iff (rst)
    (op == OP_LOAD) |-> (regWrEn && !memWrEn && (regWrAddr == instrOut[20:16])));

  // R6
  a_r6_store_only: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STORE) |-> (memWrEn && !regWrEn));

  // R7
  a_r7_beq_next: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ) |=> ((pcOut == $past(seqPc)) || (pcOut == $past(brTgt))));

  a_r7_beq_quiet: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ) |-> (!regWrEn && !memWrEn));

  // R8
  a_r8_jump_next: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JUMP) |=> (pcOut == $past(jTgt)));

  // R10
  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    !isKnown |-> (!regWrEn && !memWrEn));

endmodule

bind scpu_core scpu_core_checker u_checker (
  .clk      (clk),
  .rst      (rst),
  .pcOut    (pcOut),
  .instrOut (instrOut),
  .regWrEn  (regWrEn),
  .regWrAddr(regWrAddr),
  .memWrEn  (memWrEn)
);

// File: tb/scpu_core_bench.sv
`timescale 1ns/1ps
module scpu_core_bench;

  localparam int WORDS  = 64;
  localparam int NSTEPS = 30;
  localparam int MAXCYC = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcOut, instrOut, regWrData, memAddr, memWrData;
  logic        regWrEn, memWrEn;
  logic [4:0]  regWrAddr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  scpu_core u_scpu_core (
    .clk(clk), .rst(rst), .pcOut(pcOut), .instrOut(instrOut),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData)
  );

  typedef struct packed {
    logic [31:0] pc;
    logic        rWe;
    logic [4:0]  rA;
    logic [31:0] rD;
    logic        mWe;
    logic [31:0] mA;
    logic [31:0] mD;
  } item_t;

  item_t expQ[$];
  string tagQ[$];
  string pcTagQ[$];

  logic [31:0] progM [WORDS];
  logic [31:0] dataM [WORDS];
  logic [31:0] regM  [32];

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int idx);
    return {6'h02, 26'(idx)};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  // Driver: reference model of the requirements, pushes one item per cycle
  task automatic driveExpect(int steps);
    logic [31:0] pc = 0;
    string pcTag = "R1";
    for (int s = 0; s < steps; s++) begin
      logic [31:0] ins = progM[pc[7:2]];
      logic [5:0]  op = ins[31:26];
      int rs = ins[25:21], rt = ins[20:16], rd = ins[15:11];
      logic [31:0] a = regM[rs], b = regM[rt];
      logic [31:0] ext = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] nxt = pc + 4;
      string tag = "R10";
      string nTag = "R2";
      item_t it = '0;
      it.pc = pc;
      if (op == 6'h00) begin
        it.rA = 5'(rd);
        it.rWe = 1'b1;
        tag = "R3";
        case (ins[5:0])
          6'h20: it.rD = a + b;
          6'h22: it.rD = a - b;
          6'h24: it.rD = a & b;
          6'h25: it.rD = a | b;
          6'h2A: begin it.rD = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
          default: begin it.rWe = 1'b0; tag = "R10"; end
        endcase
        if (it.rWe && rd == 0) tag = "R9";
        else if (it.rWe && (rd == rs || rd == rt)) tag = "R11";
      end else if (op == 6'h23) begin
        it.rWe = 1'b1; it.rA = 5'(rt); it.rD = dataM[(a + ext) >> 2]; tag = "R5";
      end else if (op == 6'h2B) begin
        it.mWe = 1'b1; it.mA = a + ext; it.mD = b;
        tag = (rt == 0) ? "R9" : "R6";
      end else if (op == 6'h04) begin
        tag = "R7"; nTag = "R7";
        if (a == b) nxt = pc + 4 + {ext[29:0], 2'b00};
      end else if (op == 6'h02) begin
        tag = "R8"; nTag = "R8";
        nxt = {nxt[31:28], ins[25:0], 2'b00};
      end
      if (it.rWe && it.rA != 0) regM[it.rA] = it.rD;
      if (it.mWe) dataM[it.mA >> 2] = it.mD;
      expQ.push_back(it);
      tagQ.push_back(tag);
      pcTagQ.push_back(pcTag);
      pcTag = nTag;
      pc = nxt;
    end
  endtask

  // Monitor: pops one item per cycle and compares away from the edge
  task automatic monitor();
    while (expQ.size() > 0) begin
      item_t e = expQ.pop_front();
      string t = tagQ.pop_front();
      string pt = pcTagQ.pop_front();
      #1;
      check(pt, "pc", pcOut, e.pc);
      check(t, "regWrEn", 32'(regWrEn), 32'(e.rWe));
      if (e.rWe) begin
        check(t, "regWrAddr", 32'(regWrAddr), 32'(e.rA));
        check(t, "regWrData", regWrData, e.rD);
      end
      check(t, "memWrEn", 32'(memWrEn), 32'(e.mWe));
      if (e.mWe) begin
        check(t, "memAddr", memAddr, e.mA);
        check(t, "memWrData", memWrData, e.mD);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin progM[i] = 32'hFC00_0000; dataM[i] = 32'h0; end
    for (int i = 0; i < 32; i++) regM[i] = 32'h0;
    dataM[0] = 32'h0000_0007;
    dataM[1] = 32'hFFFF_FFFD;
    progM[0]  = encI(6'h23, 0, 1, 0);        // load r1
    progM[1]  = encI(6'h23, 0, 2, 4);        // load r2
    progM[2]  = encR(1, 2, 3, 6'h20);        // add
    progM[3]  = encR(1, 2, 4, 6'h22);        // sub
    progM[4]  = encR(1, 2, 5, 6'h24);        // and
    progM[5]  = encR(1, 2, 6, 6'h25);        // or
    progM[6]  = encR(2, 1, 7, 6'h2A);        // slt, negative < positive
    progM[7]  = encR(1, 2, 8, 6'h2A);        // slt, false
    progM[8]  = encR(1, 1, 0, 6'h20);        // write to r0 (R9)
    progM[9]  = encI(6'h2B, 0, 0, 8);        // store r0 -> shows zero (R9)
    progM[10] = encI(6'h2B, 3, 4, -4);       // store with negative offset
    progM[11] = encI(6'h23, 0, 9, 0);        // load back stored word
    progM[12] = encR(1, 1, 1, 6'h20);        // r1 = r1 + r1 (R11)
    progM[13] = encI(6'h2B, 0, 1, 12);       // expose r1
    progM[14] = encI(6'h04, 1, 2, 5);        // branch not taken
    progM[15] = encI(6'h04, 3, 3, 2);        // branch taken -> word 18
    progM[16] = encR(1, 1, 10, 6'h20);
    progM[17] = encR(1, 1, 10, 6'h20);
    progM[18] = encJ(22);                    // jump -> word 22
    progM[19] = encR(1, 1, 11, 6'h20);
    progM[22] = 32'hFC00_0000;               // undefined opcode
    progM[23] = encI(6'h04, 0, 0, 1);        // branch taken -> word 25
    progM[24] = encR(1, 1, 12, 6'h20);
    progM[25] = encJ(25);                    // self loop
    for (int i = 0; i < WORDS; i++) begin
      u_scpu_core.u_datapath.u_imem.words[i] = progM[i];
      u_scpu_core.u_datapath.u_dmem.words[i] = dataM[i];
    end
    driveExpect(NSTEPS);

    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "pc in reset", pcOut, 32'h0);
    rst = 1'b0;
    monitor();

    rst = 1'b1;
    @(negedge clk);
    check("R1", "pc after mid-run reset", pcOut, 32'h0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (MAXCYC) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule